// File: doc/BRIEF.md
# Raster Position Capture and Scan Status Unit

This unit sits on the register bus of a video timing controller. It takes a snapshot of the live horizontal and vertical beam counters and keeps it in two read-only words. A snapshot is taken on one of two triggers, chosen by a source-select bit. The first is a host read of the control word. The second is the rising edge of an asynchronous external strobe, such as a light-gun photodetector pulse. The strobe is synchronized to the system clock before it is used. The unit also reports a live scan-status word with blanking, field and video-system bits. The same word carries two sticky event flags that clear when the status word is read.

The H and V values are packed when they are captured. The packing depends on the graphic-mode and interlace inputs at the moment of capture, and the packed values stay the same until the next capture. Software therefore always reads an H/V pair taken at the same instant. Three control bits (sync-input enable, full-area select and external-screen enable) are stored here and driven out to the blocks that use them.

Top module: `beam_pos_capture`

## Requirements
- R1: Word addresses are 0 = control, 1 = status, 2 = H capture, 3 = V capture. Read data appears on `hostRdata` the cycle after `hostRd` and holds until the next read. The control word stores bit 9 (capture source, 1 = external), bit 8 (sync-input enable), bit 1 (full-area select) and bit 0 (external-screen enable). Its other bits read as 0, and reset clears it. Bits 8, 1 and 0 drive `extSyncEn`, `areaSelAll` and `extScreenEn`.
- R2: With capture source 0, every host read of the control word captures the counters. External strobes then capture nothing and leave status bit 9 at 0.
- R3: With capture source 1, each rising edge of `extLatchIn` (after synchronization) captures the counters exactly once, however long the pulse lasts, and sets status bit 9. A host read of the control word does not capture.
- R4: A `syncLockPulse` sets status bit 8 only while control bit 8 is 1. Otherwise it is ignored.
- R5: Reading the status word returns the flags and then clears bits 9 and 8. A set event in the same cycle as that read wins, so the flag reads 1 on the next read.
- R6: Status bit 3 is vertical blank, bit 2 is horizontal blank (live), bit 1 is odd field (1 = odd) and bit 0 is the video system (1 = PAL, 0 = NTSC).
- R7: Status bit 3 reads 1 whenever `dispOn` is 0.
- R8: Status bit 1 reads 1 whenever `interlaceOn` is 0. Otherwise it follows `fieldOdd`.
- R9: The H capture word is packed according to `gfxMode`:
  - 0 (normal): H[8:0] in bits 9..1, with bit 0 = 0;
  - 1 (high-res): H[9:0] in bits 9..0;
  - 2 (exclusive normal): H[8:0] in bits 8..0;
  - 3 (exclusive high-res): H[9:1] in bits 8..0.
- R10: When `interlaceOn` and `doubleDensity` are both 1, the V capture word holds V[8:0] in bits 9..1 and the field in bit 0 (0 = odd, 1 = even). In every other case V[9:0] fills bits 9..0.
- R11: Bits 15..10 of the status, H and V words read 0. Host writes to addresses 1, 2 and 3 change nothing.
- R12: The captured H and V words hold their values until the next capture, whatever the live counters do. After reset they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 2 | Word select |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Registered read data |
| hPos | input | 10 | Live horizontal counter |
| vPos | input | 10 | Live vertical counter |
| hBlank | input | 1 | Horizontal blanking active |
| vBlank | input | 1 | Vertical blanking active |
| fieldOdd | input | 1 | Current field is odd |
| dispOn | input | 1 | Display enabled |
| interlaceOn | input | 1 | Interlaced scan |
| doubleDensity | input | 1 | Double-density interlace |
| gfxMode | input | 2 | H packing mode |
| palSystem | input | 1 | 1 = PAL timing, 0 = NTSC |
| extLatchIn | input | 1 | Asynchronous external capture strobe |
| syncLockPulse | input | 1 | One-cycle pulse: timing locked to external sync |
| extSyncEn | output | 1 | Control bit 8 |
| areaSelAll | output | 1 | Control bit 1 |
| extScreenEn | output | 1 | Control bit 0 |

## Verification
Assertions check every cycle that:
- the read word holds between reads;
- its top bits stay zero;
- the forced vertical-blank and odd-field bits and the live PAL bit appear in status reads;
- the control outputs follow writes;
- a synchronized strobe edge lasts one cycle only.

The bench scenarios check the rest:
- the capture source choice;
- a single capture from a long strobe;
- set-over-clear on the sticky flags;
- every H and V packing mode;
- that the captured pair stays fixed while the live counters move.

// File: rtl/beam_pos_pkg.sv
package beam_pos_pkg;

  typedef enum logic [1:0] {
    ADDR_CONTROL = 2'd0,
    ADDR_STATUS  = 2'd1,
    ADDR_HCAP    = 2'd2,
    ADDR_VCAP    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    GFX_NORMAL      = 2'd0,
    GFX_HIRES       = 2'd1,
    GFX_EXCL_NORMAL = 2'd2,
    GFX_EXCL_HIRES  = 2'd3
  } gfxMode_e;

  // control word bit positions
  localparam int unsigned CTL_SRC_BIT    = 9;
  localparam int unsigned CTL_SYNC_BIT   = 8;
  localparam int unsigned CTL_AREA_BIT   = 1;
  localparam int unsigned CTL_SCREEN_BIT = 0;

  // status word bit positions
  localparam int unsigned ST_LATCH_BIT = 9;
  localparam int unsigned ST_SYNC_BIT  = 8;
  localparam int unsigned ST_VBL_BIT   = 3;
  localparam int unsigned ST_HBL_BIT   = 2;
  localparam int unsigned ST_ODD_BIT   = 1;
  localparam int unsigned ST_PAL_BIT   = 0;

  typedef struct packed {
    logic wrControl;   // host writes control word
    logic capture;     // take a counter snapshot this cycle
    logic extCapture;  // snapshot came from the external strobe
    logic setSync;     // sync-lock event accepted
    logic clrFlags;    // status word read
    logic rdLoad;      // load read data register
  } ctrlStrobe_t;

endpackage

// File: rtl/beam_pos_ctrl.sv
module beam_pos_ctrl
  import beam_pos_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [1:0]  hostAddr,
  input  logic        srcExternal,
  input  logic        syncInputEn,
  input  logic        extLatchIn,
  input  logic        syncLockPulse,
  output ctrlStrobe_t strobe
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   extEdge;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= extLatchIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncChain[TOP];
  end

  assign extEdge = syncChain[TOP] & ~prevLevel;

  logic ctlRead;
  assign ctlRead = hostRd && (regSel_e'(hostAddr) == ADDR_CONTROL);

  always_comb begin
    strobe            = '0;
    strobe.wrControl  = hostWr && (regSel_e'(hostAddr) == ADDR_CONTROL);
    strobe.extCapture = extEdge && srcExternal;
    strobe.capture    = (ctlRead && !srcExternal) || strobe.extCapture;
    strobe.setSync    = syncLockPulse && syncInputEn;
    strobe.clrFlags   = hostRd && (regSel_e'(hostAddr) == ADDR_STATUS);
    strobe.rdLoad     = hostRd;
  end

endmodule

// File: rtl/beam_pos_dp.sv
module beam_pos_dp
  import beam_pos_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [CNT_W-1:0]  hPos,
  input  logic [CNT_W-1:0]  vPos,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic              fieldOdd,
  input  logic              dispOn,
  input  logic              interlaceOn,
  input  logic              doubleDensity,
  input  logic [1:0]        gfxMode,
  input  logic              palSystem,
  output logic              srcExternal,
  output logic              syncInputEn,
  output logic              areaAll,
  output logic              screenEn,
  output logic [DATA_W-1:0] hostRdata
);

  logic [CNT_W-1:0]  capH, capV, packedH, packedV;
  logic              latchFlag, syncFlag;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWdata;

  assign unusedWdata = ^hostWdata;

  // H packing by graphic mode
  always_comb begin
    packedH = '0;
    unique case (gfxMode_e'(gfxMode))
      GFX_NORMAL:      packedH = {hPos[CNT_W-2:0], 1'b0};
      GFX_HIRES:       packedH = hPos;
      GFX_EXCL_NORMAL: packedH = {1'b0, hPos[CNT_W-2:0]};
      GFX_EXCL_HIRES:  packedH = {1'b0, hPos[CNT_W-1:1]};
      default:         packedH = '0;
    endcase
  end

  // V packing: double-density interlace carries the field in bit 0
  always_comb begin
    if (interlaceOn && doubleDensity) packedV = {vPos[CNT_W-2:0], ~fieldOdd};
    else                              packedV = vPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcExternal <= 1'b0;
      syncInputEn <= 1'b0;
      areaAll     <= 1'b0;
      screenEn    <= 1'b0;
    end else if (strobe.wrControl) begin
      srcExternal <= hostWdata[CTL_SRC_BIT];
      syncInputEn <= hostWdata[CTL_SYNC_BIT];
      areaAll     <= hostWdata[CTL_AREA_BIT];
      screenEn    <= hostWdata[CTL_SCREEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capH <= '0;
      capV <= '0;
    end else if (strobe.capture) begin
      capH <= packedH;
      capV <= packedV;
    end
  end

  // sticky flags: set has priority over read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchFlag <= 1'b0;
      syncFlag  <= 1'b0;
    end else begin
      if (strobe.extCapture)    latchFlag <= 1'b1;
      else if (strobe.clrFlags) latchFlag <= 1'b0;
      if (strobe.setSync)       syncFlag  <= 1'b1;
      else if (strobe.clrFlags) syncFlag  <= 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (regSel_e'(hostAddr))
      ADDR_CONTROL: begin
        rdNext[CTL_SRC_BIT]    = srcExternal;
        rdNext[CTL_SYNC_BIT]   = syncInputEn;
        rdNext[CTL_AREA_BIT]   = areaAll;
        rdNext[CTL_SCREEN_BIT] = screenEn;
      end
      ADDR_STATUS: begin
        rdNext[ST_LATCH_BIT] = latchFlag;
        rdNext[ST_SYNC_BIT]  = syncFlag;
        rdNext[ST_VBL_BIT]   = vBlank | ~dispOn;
        rdNext[ST_HBL_BIT]   = hBlank;
        rdNext[ST_ODD_BIT]   = fieldOdd | ~interlaceOn;
        rdNext[ST_PAL_BIT]   = palSystem;
      end
      ADDR_HCAP: rdNext[CNT_W-1:0] = capH;
      ADDR_VCAP: rdNext[CNT_W-1:0] = capV;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hostRdata <= '0;
    else if (strobe.rdLoad) hostRdata <= rdNext;
  end

endmodule

// File: rtl/beam_pos_capture.sv
module beam_pos_capture
  import beam_pos_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [CNT_W-1:0]  hPos,
  input  logic [CNT_W-1:0]  vPos,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic              fieldOdd,
  input  logic              dispOn,
  input  logic              interlaceOn,
  input  logic              doubleDensity,
  input  logic [1:0]        gfxMode,
  input  logic              palSystem,
  input  logic              extLatchIn,
  input  logic              syncLockPulse,
  output logic              extSyncEn,
  output logic              areaSelAll,
  output logic              extScreenEn
);

  ctrlStrobe_t strobe;
  logic        srcExternal;

  beam_pos_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .hostRd        (hostRd),
    .hostWr        (hostWr),
    .hostAddr      (hostAddr),
    .srcExternal   (srcExternal),
    .syncInputEn   (extSyncEn),
    .extLatchIn    (extLatchIn),
    .syncLockPulse (syncLockPulse),
    .strobe        (strobe)
  );

  beam_pos_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .hostAddr      (hostAddr),
    .hostWdata     (hostWdata),
    .hPos          (hPos),
    .vPos          (vPos),
    .hBlank        (hBlank),
    .vBlank        (vBlank),
    .fieldOdd      (fieldOdd),
    .dispOn        (dispOn),
    .interlaceOn   (interlaceOn),
    .doubleDensity (doubleDensity),
    .gfxMode       (gfxMode),
    .palSystem     (palSystem),
    .srcExternal   (srcExternal),
    .syncInputEn   (extSyncEn),
    .areaAll       (areaSelAll),
    .screenEn      (extScreenEn),
    .hostRdata     (hostRdata)
  );

endmodule

// File: rtl/beam_pos_capture_chk.sv
module beam_pos_capture_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRd,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic [DATA_W-1:0] hostRdata,
  input logic              dispOn,
  input logic              interlaceOn,
  input logic              palSystem,
  input logic              extSyncEn,
  input logic              areaSelAll,
  input logic              extScreenEn,
  input logic              extCapture
);

  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> $stable(hostRdata));

  a_r1_ctl_outputs: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0) |=>
      (extSyncEn == $past(hostWdata[8]) && areaSelAll == $past(hostWdata[1]) &&
       extScreenEn == $past(hostWdata[0])));

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> (hostRdata[DATA_W-1:10] == '0));

  a_r7_vblank_forced: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd1 && !dispOn) |=> hostRdata[3]);

  a_r8_odd_forced: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd1 && !interlaceOn) |=> hostRdata[1]);

  a_r6_pal_bit: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd1) |=> (hostRdata[0] == $past(palSystem)));

  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    extCapture |=> !extCapture);

endmodule

bind beam_pos_capture beam_pos_capture_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .hostRd      (hostRd),
  .hostWr      (hostWr),
  .hostAddr    (hostAddr),
  .hostWdata   (hostWdata),
  .hostRdata   (hostRdata),
  .dispOn      (dispOn),
  .interlaceOn (interlaceOn),
  .palSystem   (palSystem),
  .extSyncEn   (extSyncEn),
  .areaSelAll  (areaSelAll),
  .extScreenEn (extScreenEn),
  .extCapture  (strobe.extCapture)
);

// File: tb/beam_pos_capture_tb.sv
module beam_pos_capture_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [9:0]  hPos = '0, vPos = '0;
  logic        hBlank = 1'b0, vBlank = 1'b0, fieldOdd = 1'b0, dispOn = 1'b1;
  logic        interlaceOn = 1'b0, doubleDensity = 1'b0, palSystem = 1'b0;
  logic [1:0]  gfxMode = 2'd1;
  logic        extLatchIn = 1'b0, syncLockPulse = 1'b0;
  logic        extSyncEn, areaSelAll, extScreenEn;

  always #2.5 clk = ~clk;

  beam_pos_capture dut_i (.*);

  typedef struct {
    logic [15:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  vectors = 0;
  int  miscompares = 0;
  logic rdPend = 1'b0;
  bit  finished = 1'b0;

  always @(posedge clk) rdPend <= hostRd;

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rdPend) begin
      expItem_t e;
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL %s: unexpected read data %h", "scoreboard", hostRdata);
      end else begin
        e = expQ.pop_front();
        if (hostRdata !== e.data) begin
          miscompares++;
          $display("FAIL %s: got %h expected %h", e.tag, hostRdata, e.data);
        end
      end
    end
  end

  task automatic hostRead(input logic [1:0] a, input logic [15:0] exp, input string tag);
    expItem_t e;
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    e.data = exp; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic checkVal(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 / R12: reset state
    checkVal({13'd0, extSyncEn, areaSelAll, extScreenEn}, 16'h0, "R1 reset outputs");
    hostRead(2'd0, 16'h0000, "R1 reset control");
    hostRead(2'd1, 16'h0002, "R8 reset status odd forced");
    hostRead(2'd2, 16'h0000, "R12 reset H");
    hostRead(2'd3, 16'h0000, "R12 reset V");

    // R1: only stored control bits read back
    hostWrite(2'd0, 16'hFFFF);
    checkVal({13'd0, extSyncEn, areaSelAll, extScreenEn}, 16'h0007, "R1 control outputs");
    hostRead(2'd0, 16'h0303, "R1 control readback");
    hostWrite(2'd0, 16'h0000);
    checkVal({13'd0, extSyncEn, areaSelAll, extScreenEn}, 16'h0000, "R1 control cleared");

    // R2: capture on control read
    hPos = 10'h2A5; vPos = 10'h3C7; gfxMode = 2'd1;
    hostRead(2'd0, 16'h0000, "R2 control read");
    hPos = 10'h000; vPos = 10'h000;
    hostRead(2'd2, 16'h02A5, "R12 H held after live change");
    hostRead(2'd3, 16'h03C7, "R12 V held after live change");

    // R2: external strobe ignored with source 0
    hPos = 10'h111;
    @(negedge clk); extLatchIn = 1'b1;
    waitCycles(5);
    extLatchIn = 1'b0;
    waitCycles(5);
    hostRead(2'd2, 16'h02A5, "R2 strobe ignored H");
    hostRead(2'd1, 16'h0002, "R2 strobe sets no flag");

    // R9: H packing per mode
    hPos = 10'h2A5;
    gfxMode = 2'd0;
    hostRead(2'd0, 16'h0000, "R9 capture normal");
    hostRead(2'd2, 16'h014A, "R9 normal packing");
    gfxMode = 2'd2;
    hostRead(2'd0, 16'h0000, "R9 capture excl normal");
    hostRead(2'd2, 16'h00A5, "R9 exclusive normal packing");
    gfxMode = 2'd3;
    hostRead(2'd0, 16'h0000, "R9 capture excl hires");
    hostRead(2'd2, 16'h0152, "R9 exclusive high-res packing");
    gfxMode = 2'd1;

    // R10: V packing
    vPos = 10'h3C7; interlaceOn = 1'b1; doubleDensity = 1'b1; fieldOdd = 1'b1;
    hostRead(2'd0, 16'h0000, "R10 capture double odd");
    hostRead(2'd3, 16'h038E, "R10 double density odd field");
    fieldOdd = 1'b0;
    hostRead(2'd0, 16'h0000, "R10 capture double even");
    hostRead(2'd3, 16'h038F, "R10 double density even field");
    doubleDensity = 1'b0;
    hostRead(2'd0, 16'h0000, "R10 capture single density");
    hostRead(2'd3, 16'h03C7, "R10 single density full V");
    interlaceOn = 1'b0;

    // R3: external source
    hostWrite(2'd0, 16'h0200);
    hPos = 10'h123;
    hostRead(2'd0, 16'h0200, "R3 control read no capture");
    hostRead(2'd2, 16'h02A5, "R3 control read did not capture");
    @(negedge clk); extLatchIn = 1'b1;
    waitCycles(4);
    hPos = 10'h3FF;
    waitCycles(4);
    extLatchIn = 1'b0;
    waitCycles(4);
    hostRead(2'd2, 16'h0123, "R3 one capture per pulse");
    hostRead(2'd3, 16'h03C7, "R3 V captured by strobe");
    hostRead(2'd1, 16'h0202, "R3 latch flag set");
    hostRead(2'd1, 16'h0002, "R5 latch flag cleared by read");

    // R4: sync flag gated by enable
    @(negedge clk); syncLockPulse = 1'b1;
    @(negedge clk); syncLockPulse = 1'b0;
    hostRead(2'd1, 16'h0002, "R4 sync pulse ignored");
    hostWrite(2'd0, 16'h0300);
    @(negedge clk); syncLockPulse = 1'b1;
    @(negedge clk); syncLockPulse = 1'b0;
    hostRead(2'd1, 16'h0102, "R4 sync flag set");
    hostRead(2'd1, 16'h0002, "R5 sync flag cleared");

    // R5: set wins over read-clear
    begin
      expItem_t e;
      @(negedge clk);
      hostRd = 1'b1; hostAddr = 2'd1; syncLockPulse = 1'b1;
      e.data = 16'h0002; e.tag = "R5 read in set cycle";
      expQ.push_back(e);
      @(negedge clk);
      hostRd = 1'b0; syncLockPulse = 1'b0;
    end
    hostRead(2'd1, 16'h0102, "R5 set wins over clear");

    // R6 / R7 / R8: live status bits
    dispOn = 1'b0; vBlank = 1'b0; hBlank = 1'b1; palSystem = 1'b1;
    interlaceOn = 1'b1; fieldOdd = 1'b0;
    hostRead(2'd1, 16'h000D, "R7 vblank forced by display off");
    dispOn = 1'b1; vBlank = 1'b1; fieldOdd = 1'b1;
    hostRead(2'd1, 16'h000F, "R6 all live bits set");
    vBlank = 1'b0; hBlank = 1'b0; palSystem = 1'b0; fieldOdd = 1'b0;
    hostRead(2'd1, 16'h0000, "R6 all live bits clear");

    // R11: writes to read-only words ignored
    hostWrite(2'd1, 16'hFFFF);
    hostWrite(2'd2, 16'hFFFF);
    hostWrite(2'd3, 16'hFFFF);
    hostRead(2'd2, 16'h0123, "R11 H write ignored");
    hostRead(2'd3, 16'h03C7, "R11 V write ignored");
    hostRead(2'd1, 16'h0000, "R11 status write ignored");
    hostRead(2'd0, 16'h0300, "R11 control unchanged");

    waitCycles(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule